// File: doc/BRIEF.md
# Dual-Group Storage Bus Transceiver

This block moves data in both directions between a push-pull "A" side and a wired-OR "B" side. It is split into two independent groups, one 8 bits wide and one 9 bits wide. Each group has an A-to-B path and a B-to-A path. Every bit of each path goes through a storage element that, on each system clock edge, is loaded from its input, loaded only on a rising edge of its strobe, or left unchanged. The path's latch-enable and strobe inputs pick which of these happens. Both strobes are sampled by the system clock.

On the B side each bit is an open-drain pull-down, so a line is either pulled low or released. A stored 0 pulls the line low and a stored 1 releases it. On the A side each group drives a tri-state bus whose data is the inverse of the stored B-to-A value, with one output-enable for the whole group. Each side is turned on by an active-high enable and an active-low enable, and the two must agree. A shared power-good input releases both sides of both groups. The 9-bit group also sends a buffered copy of its A-to-B strobe to a separate output.

All outputs are registered. A change at the inputs in the cycle before clock edge t shows at the outputs just after edge t. The reset is synchronous and active-high.

Top module: `bus_xcvr_store`

## Requirements
- R1: While `rst` is high at a clock edge, every storage element is set to all ones and its strobe history to 0. After that edge `*_b_pull` is all zeros, `*_a_oe` is 0, `*_a_out` is all zeros and `g1_stb_fwd` is 0.
- R2: When a path's latch enable is high at an edge, that path's storage takes the input present at that edge.
- R3: When the latch enable is low, the storage takes its input at an edge where the strobe is 1 and was 0 at the previous edge.
- R4: When the latch enable is low and there is no strobe rise, the storage keeps its value. This includes a strobe that stays high.
- R5: B side is open-drain. When enabled, `b_pull[i]` is 1 exactly when stored A-to-B bit i is 0. A 1 is always shown as release (`b_pull[i]`=0).
- R6: The B side is enabled only when `oeb`=1, `oeb_n`=0 and `pwr_ok`=1. In every other case `b_pull` is all zeros.
- R7: `a_oe` is 1 only when `oea`=1, `oea_n`=0 and `pwr_ok`=1.
- R8: `a_out` is the bitwise inverse of the stored B-to-A value.
- R9: With `pwr_ok`=0, both sides of both groups are released. Stored values are not changed, and they reappear once power returns.
- R10: The two groups share only clock, reset and `pwr_ok`. The controls and data of one group never change the other group's outputs.
- R11: `g1_stb_fwd` equals the value of `g1_stb_ab` sampled at the previous edge.
- R12: Both directions of a group may be enabled at once, and each direction keeps operating independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Power good; low releases every output |
| g0_a_in | input | 8 | Group 0 A-side data in |
| g0_b_in | input | 8 | Group 0 B-side line levels |
| g0_le_ab | input | 1 | Group 0 A-to-B latch enable |
| g0_stb_ab | input | 1 | Group 0 A-to-B strobe |
| g0_le_ba | input | 1 | Group 0 B-to-A latch enable |
| g0_stb_ba | input | 1 | Group 0 B-to-A strobe |
| g0_oea | input | 1 | Group 0 A enable, active high |
| g0_oea_n | input | 1 | Group 0 A enable, active low |
| g0_oeb | input | 1 | Group 0 B enable, active high |
| g0_oeb_n | input | 1 | Group 0 B enable, active low |
| g0_a_out | output | 8 | Group 0 A-side data out (inverted B data) |
| g0_a_oe | output | 1 | Group 0 A-side drive enable |
| g0_b_pull | output | 8 | Group 0 B-side pull-low per bit |
| g1_a_in | input | 9 | Group 1 A-side data in |
| g1_b_in | input | 9 | Group 1 B-side line levels |
| g1_le_ab | input | 1 | Group 1 A-to-B latch enable |
| g1_stb_ab | input | 1 | Group 1 A-to-B strobe |
| g1_le_ba | input | 1 | Group 1 B-to-A latch enable |
| g1_stb_ba | input | 1 | Group 1 B-to-A strobe |
| g1_oea | input | 1 | Group 1 A enable, active high |
| g1_oea_n | input | 1 | Group 1 A enable, active low |
| g1_oeb | input | 1 | Group 1 B enable, active high |
| g1_oeb_n | input | 1 | Group 1 B enable, active low |
| g1_a_out | output | 9 | Group 1 A-side data out (inverted B data) |
| g1_a_oe | output | 1 | Group 1 A-side drive enable |
| g1_b_pull | output | 9 | Group 1 B-side pull-low per bit |
| g1_stb_fwd | output | 1 | Buffered copy of g1_stb_ab |

## Verification
The bench holds a strobe high across several edges while the data changes. A design that triggers on level instead of on a rise would pick up the new data there, when it should hold. It walks all four combinations of each enable pair. Enables that OR their inputs, or ignore the active-low one, would drive a side that should be released. It drops power and then restores it with the latch enables low. A design that cleared or reloaded its storage on power loss would come back with different bus values. Random traffic on both groups at once exposes a mix-up between groups or directions, a missing inversion on the A side, and a wrong pull polarity on the B side.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Action taken by one path's storage at a clock edge.
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;

  // Both polarities of an enable pair must agree, and power must be good.
  function automatic logic pair_enabled(input logic en_hi, input logic en_lo_n,
                                        input logic pwr);
    return en_hi & ~en_lo_n & pwr;
  endfunction

endpackage

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_next,
  output logic [W-1:0] q
);

  logic        stb_d;
  store_mode_e mode;

  always_comb begin
    if (le)
      mode = MODE_PASS;
    else if (stb && !stb_d)
      mode = MODE_CAPTURE;
    else
      mode = MODE_HOLD;
  end

  always_comb begin
    unique case (mode)
      MODE_PASS, MODE_CAPTURE: q_next = d;
      default:                 q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '1;
      stb_d <= 1'b0;
    end else begin
      q     <= q_next;
      stb_d <= stb;
    end
  end

endmodule

// File: rtl/xcvr_enable_gate.sv
module xcvr_enable_gate
  import xcvr_pkg::*;
(
  input  logic en_hi,
  input  logic en_lo_n,
  input  logic pwr_ok,
  output logic active
);

  assign active = pair_enabled(en_hi, en_lo_n, pwr_ok);

endmodule

// File: rtl/xcvr_group.sv
module xcvr_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_ok,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         le_ab,
  input  logic         stb_ab,
  input  logic         le_ba,
  input  logic         stb_ba,
  input  logic         oea,
  input  logic         oea_n,
  input  logic         oeb,
  input  logic         oeb_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_pull
);

  logic [W-1:0] ab_next, ab_q;
  logic [W-1:0] ba_next, ba_q;
  logic         a_on, b_on;

  xcvr_store_cell #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .le(le_ab), .stb(stb_ab), .d(a_in),
    .q_next(ab_next), .q(ab_q)
  );

  xcvr_store_cell #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .le(le_ba), .stb(stb_ba), .d(b_in),
    .q_next(ba_next), .q(ba_q)
  );

  xcvr_enable_gate u_a_en (.en_hi(oea), .en_lo_n(oea_n), .pwr_ok(pwr_ok), .active(a_on));
  xcvr_enable_gate u_b_en (.en_hi(oeb), .en_lo_n(oeb_n), .pwr_ok(pwr_ok), .active(b_on));

  // Output registers are loaded from the storage's next value, so the ports
  // carry one cycle of latency in total, the same as the storage itself.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_out  <= '0;
      a_oe   <= 1'b0;
      b_pull <= '0;
    end else begin
      a_out  <= ~ba_next;
      a_oe   <= a_on;
      b_pull <= b_on ? ~ab_next : '0;
    end
  end

  // Keeps the registered copies in the design, so the storage is a true holder.
  logic unused_q;
  assign unused_q = ^{ab_q, ba_q};

endmodule

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
  parameter int G0_W = 8,
  parameter int G1_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_ok,
  input  logic [G0_W-1:0] g0_a_in,
  input  logic [G0_W-1:0] g0_b_in,
  input  logic            g0_le_ab,
  input  logic            g0_stb_ab,
  input  logic            g0_le_ba,
  input  logic            g0_stb_ba,
  input  logic            g0_oea,
  input  logic            g0_oea_n,
  input  logic            g0_oeb,
  input  logic            g0_oeb_n,
  output logic [G0_W-1:0] g0_a_out,
  output logic            g0_a_oe,
  output logic [G0_W-1:0] g0_b_pull,
  input  logic [G1_W-1:0] g1_a_in,
  input  logic [G1_W-1:0] g1_b_in,
  input  logic            g1_le_ab,
  input  logic            g1_stb_ab,
  input  logic            g1_le_ba,
  input  logic            g1_stb_ba,
  input  logic            g1_oea,
  input  logic            g1_oea_n,
  input  logic            g1_oeb,
  input  logic            g1_oeb_n,
  output logic [G1_W-1:0] g1_a_out,
  output logic            g1_a_oe,
  output logic [G1_W-1:0] g1_b_pull,
  output logic            g1_stb_fwd
);

  xcvr_group #(.W(G0_W)) u_grp0 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
    .a_in(g0_a_in), .b_in(g0_b_in),
    .le_ab(g0_le_ab), .stb_ab(g0_stb_ab), .le_ba(g0_le_ba), .stb_ba(g0_stb_ba),
    .oea(g0_oea), .oea_n(g0_oea_n), .oeb(g0_oeb), .oeb_n(g0_oeb_n),
    .a_out(g0_a_out), .a_oe(g0_a_oe), .b_pull(g0_b_pull)
  );

  xcvr_group #(.W(G1_W)) u_grp1 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
    .a_in(g1_a_in), .b_in(g1_b_in),
    .le_ab(g1_le_ab), .stb_ab(g1_stb_ab), .le_ba(g1_le_ba), .stb_ba(g1_stb_ba),
    .oea(g1_oea), .oea_n(g1_oea_n), .oeb(g1_oeb), .oeb_n(g1_oeb_n),
    .a_out(g1_a_out), .a_oe(g1_a_oe), .b_pull(g1_b_pull)
  );

  // Buffered strobe of the wide group, registered like every other output.
  always_ff @(posedge clk) begin
    if (rst) g1_stb_fwd <= 1'b0;
    else     g1_stb_fwd <= g1_stb_ab;
  end

endmodule

// File: rtl/xcvr_store_chk.sv
module xcvr_store_chk #(
  parameter int G0_W = 8,
  parameter int G1_W = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            pwr_ok,
  input logic [G0_W-1:0] g0_a_in,
  input logic            g0_le_ab,
  input logic            g0_stb_ab,
  input logic            g0_oea,
  input logic            g0_oea_n,
  input logic            g0_oeb,
  input logic            g0_oeb_n,
  input logic            g0_a_oe,
  input logic [G0_W-1:0] g0_b_pull,
  input logic [G1_W-1:0] g1_b_in,
  input logic            g1_le_ba,
  input logic            g1_stb_ab,
  input logic            g1_oeb,
  input logic            g1_oeb_n,
  input logic [G1_W-1:0] g1_a_out,
  input logic            g1_a_oe,
  input logic [G1_W-1:0] g1_b_pull,
  input logic            g1_stb_fwd
);

  // R6: a B side that is not fully enabled releases every line
  p_boff_g0_r6: assert property (@(posedge clk) disable iff (rst)
    !(g0_oeb && !g0_oeb_n && pwr_ok) |=> (g0_b_pull == '0));
  p_boff_g1_r6: assert property (@(posedge clk) disable iff (rst)
    !(g1_oeb && !g1_oeb_n && pwr_ok) |=> (g1_b_pull == '0));

  // R7: the A drive enable follows the enable pair
  p_aon_r7: assert property (@(posedge clk) disable iff (rst)
    (g0_oea && !g0_oea_n && pwr_ok) |=> g0_a_oe);
  p_aoff_r7: assert property (@(posedge clk) disable iff (rst)
    !(g0_oea && !g0_oea_n && pwr_ok) |=> !g0_a_oe);

  // R9: power loss releases both sides of both groups
  p_pwr_r9: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (g0_b_pull == '0 && g1_b_pull == '0 && !g0_a_oe && !g1_a_oe));

  // R2 with R5: transparent A-to-B path shows zeros as pulls
  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (g0_le_ab && g0_oeb && !g0_oeb_n && pwr_ok) |=> (g0_b_pull == ~$past(g0_a_in)));

  // R8: transparent B-to-A path presents inverted data
  p_inv_r8: assert property (@(posedge clk) disable iff (rst)
    g1_le_ba |=> (g1_a_out == ~$past(g1_b_in)));

  // R4: no strobe rise and no latch enable keeps the pulled pattern
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !g0_le_ab && !g0_stb_ab && g0_oeb && !g0_oeb_n && pwr_ok &&
     $past(g0_oeb && !g0_oeb_n && pwr_ok)) |=> (g0_b_pull == $past(g0_b_pull)));

  // R11: forwarded strobe lags the strobe by one edge
  p_fwd_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (g1_stb_fwd == $past(g1_stb_ab)));

endmodule

bind bus_xcvr_store xcvr_store_chk #(.G0_W(G0_W), .G1_W(G1_W)) u_chk (.*);

// File: tb/sim_bus_xcvr_store.sv
module sim_bus_xcvr_store;
  localparam int W0 = 8;
  localparam int W1 = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0;
  logic [W0-1:0] g0_a_in = '0, g0_b_in = '0;
  logic [W1-1:0] g1_a_in = '0, g1_b_in = '0;
  logic g0_le_ab = 0, g0_stb_ab = 0, g0_le_ba = 0, g0_stb_ba = 0;
  logic g0_oea = 0, g0_oea_n = 1, g0_oeb = 0, g0_oeb_n = 1;
  logic g1_le_ab = 0, g1_stb_ab = 0, g1_le_ba = 0, g1_stb_ba = 0;
  logic g1_oea = 0, g1_oea_n = 1, g1_oeb = 0, g1_oeb_n = 1;
  logic [W0-1:0] g0_a_out, g0_b_pull;
  logic [W1-1:0] g1_a_out, g1_b_pull;
  logic g0_a_oe, g1_a_oe, g1_stb_fwd;

  always #4 clk = ~clk;

  bus_xcvr_store #(.G0_W(W0), .G1_W(W1)) u0 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
    .g0_a_in(g0_a_in), .g0_b_in(g0_b_in), .g0_le_ab(g0_le_ab), .g0_stb_ab(g0_stb_ab),
    .g0_le_ba(g0_le_ba), .g0_stb_ba(g0_stb_ba), .g0_oea(g0_oea), .g0_oea_n(g0_oea_n),
    .g0_oeb(g0_oeb), .g0_oeb_n(g0_oeb_n), .g0_a_out(g0_a_out), .g0_a_oe(g0_a_oe),
    .g0_b_pull(g0_b_pull),
    .g1_a_in(g1_a_in), .g1_b_in(g1_b_in), .g1_le_ab(g1_le_ab), .g1_stb_ab(g1_stb_ab),
    .g1_le_ba(g1_le_ba), .g1_stb_ba(g1_stb_ba), .g1_oea(g1_oea), .g1_oea_n(g1_oea_n),
    .g1_oeb(g1_oeb), .g1_oeb_n(g1_oeb_n), .g1_a_out(g1_a_out), .g1_a_oe(g1_a_oe),
    .g1_b_pull(g1_b_pull), .g1_stb_fwd(g1_stb_fwd)
  );

  typedef struct {
    logic [W0-1:0] b0;
    logic          oe0;
    logic [W0-1:0] a0;
    logic [W1-1:0] b1;
    logic          oe1;
    logic [W1-1:0] a1;
    logic          fwd;
    string         tag;
  } exp_t;

  exp_t q_exp[$];
  int checks = 0;
  int errors = 0;

  // Reference state built from the requirements
  logic [W0-1:0] m0ab, m0ba;
  logic [W1-1:0] m1ab, m1ba;
  logic m0abp, m0bap, m1abp, m1bap;

  function automatic logic [W1-1:0] nxt(input logic le, input logic stb, input logic stbp,
                                        input logic [W1-1:0] d, input logic [W1-1:0] q);
    return (le || (stb && !stbp)) ? d : q;   // R2, R3, R4
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [W1-1:0] act, input logic [W1-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: computes the expected outputs for the coming edge, then waits.
  task automatic cyc(input string tag);
    exp_t e;
    m0ab  = W0'(nxt(g0_le_ab, g0_stb_ab, m0abp, {1'b0, g0_a_in}, {1'b0, m0ab}));
    m0ba  = W0'(nxt(g0_le_ba, g0_stb_ba, m0bap, {1'b0, g0_b_in}, {1'b0, m0ba}));
    m1ab  = nxt(g1_le_ab, g1_stb_ab, m1abp, g1_a_in, m1ab);
    m1ba  = nxt(g1_le_ba, g1_stb_ba, m1bap, g1_b_in, m1ba);
    m0abp = g0_stb_ab; m0bap = g0_stb_ba; m1abp = g1_stb_ab; m1bap = g1_stb_ba;
    e.b0  = (pwr_ok && g0_oeb && !g0_oeb_n) ? ~m0ab : '0;   // R5, R6, R9
    e.oe0 = pwr_ok && g0_oea && !g0_oea_n;                   // R7
    e.a0  = ~m0ba;                                           // R8
    e.b1  = (pwr_ok && g1_oeb && !g1_oeb_n) ? ~m1ab : '0;
    e.oe1 = pwr_ok && g1_oea && !g1_oea_n;
    e.a1  = ~m1ba;
    e.fwd = g1_stb_ab;                                       // R11
    e.tag = tag;
    q_exp.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares each result after the edge that produces it.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q_exp.size() > 0) begin
      e = q_exp.pop_front();
      chk(e.tag, "g0_b_pull", {1'b0, g0_b_pull}, {1'b0, e.b0});
      chk(e.tag, "g0_a_oe",   {8'd0, g0_a_oe},   {8'd0, e.oe0});
      chk(e.tag, "g0_a_out",  {1'b0, g0_a_out},  {1'b0, e.a0});
      chk(e.tag, "g1_b_pull", g1_b_pull, e.b1);
      chk(e.tag, "g1_a_oe",   {8'd0, g1_a_oe},   {8'd0, e.oe1});
      chk(e.tag, "g1_a_out",  g1_a_out,  e.a1);
      chk(e.tag, "g1_stb_fwd", {8'd0, g1_stb_fwd}, {8'd0, e.fwd});
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset wins over transparent zeros with every enable on
    pwr_ok = 1;
    g0_oea = 1; g0_oea_n = 0; g0_oeb = 1; g0_oeb_n = 0;
    g1_oea = 1; g1_oea_n = 0; g1_oeb = 1; g1_oeb_n = 0;
    g0_le_ab = 1; g0_le_ba = 1; g1_le_ab = 1; g1_le_ba = 1; g1_stb_ab = 1;
    repeat (3) @(negedge clk);
    chk("R1", "g0_b_pull", {1'b0, g0_b_pull}, '0);
    chk("R1", "g1_b_pull", g1_b_pull, '0);
    chk("R1", "g0_a_oe", {8'd0, g0_a_oe}, '0);
    chk("R1", "g1_a_oe", {8'd0, g1_a_oe}, '0);
    chk("R1", "g1_a_out", g1_a_out, '0);
    chk("R1", "g1_stb_fwd", {8'd0, g1_stb_fwd}, '0);
    m0ab = '1; m0ba = '1; m1ab = '1; m1ba = '1;
    m0abp = 0; m0bap = 0; m1abp = 0; m1bap = 0;
    g0_le_ab = 0; g0_le_ba = 0; g1_le_ab = 0; g1_le_ba = 0; g1_stb_ab = 0;
    rst = 0;
    repeat (2) cyc("R1");  // storage all ones: released lines

    // R2 / R5: transparent A-to-B, zeros pull and ones release
    g0_le_ab = 1; g1_le_ab = 1;
    g0_a_in = 8'h5A; g1_a_in = 9'h0A5; cyc("R2");
    g0_a_in = 8'hA5; g1_a_in = 9'h15A; cyc("R5");
    g0_a_in = 8'h00; g1_a_in = 9'h1FF; cyc("R5");
    // R8: transparent B-to-A appears inverted
    g0_le_ba = 1; g1_le_ba = 1;
    g0_b_in = 8'h3C; g1_b_in = 9'h100; cyc("R8");
    g0_b_in = 8'hF0; g1_b_in = 9'h0FF; cyc("R8");

    // R3 / R4: strobe capture and hold, including strobe held high
    g0_le_ab = 0; g1_le_ab = 0; g0_le_ba = 0; g1_le_ba = 0;
    g0_a_in = 8'h11; g1_a_in = 9'h022; cyc("R4");
    g0_stb_ab = 1; g1_stb_ab = 1; g0_stb_ba = 1; g1_stb_ba = 1;
    g0_b_in = 8'h81; g1_b_in = 9'h181; cyc("R3");
    g0_a_in = 8'hEE; g1_a_in = 9'h1DD; g0_b_in = 8'h7E; g1_b_in = 9'h07E; cyc("R4");
    cyc("R4");
    g0_stb_ab = 0; g1_stb_ab = 0; g0_stb_ba = 0; g1_stb_ba = 0;
    g0_a_in = 8'h33; cyc("R4");
    g0_stb_ab = 1; g1_stb_ab = 1; g0_stb_ba = 1; g1_stb_ba = 1; cyc("R3");
    g0_stb_ab = 0; g1_stb_ab = 0; g0_stb_ba = 0; g1_stb_ba = 0; cyc("R11");

    // R6 / R7: every combination of each enable pair
    for (int k = 0; k < 4; k++) begin
      g0_oeb = k[0]; g0_oeb_n = k[1]; g0_oea = k[1]; g0_oea_n = k[0];
      cyc("R6");
      cyc("R7");
    end
    g0_oea = 1; g0_oea_n = 0; g0_oeb = 1; g0_oeb_n = 0;
    cyc("R6");

    // R10: group 0 controls churn while group 1 holds
    g0_le_ab = 1; g0_le_ba = 1;
    for (int k = 0; k < 4; k++) begin
      g0_a_in = 8'(k * 37); g0_b_in = 8'(k * 91); g0_oeb = k[0];
      cyc("R10");
    end
    g0_oeb = 1; g0_le_ab = 0; g0_le_ba = 0;

    // R9: power loss releases, storage kept and shown again
    pwr_ok = 0; g0_a_in = 8'h00; g1_a_in = 9'h000; cyc("R9"); cyc("R9");
    pwr_ok = 1; cyc("R9"); cyc("R9");

    // R11: forwarded strobe toggling
    for (int k = 0; k < 6; k++) begin
      g1_stb_ab = k[0]; cyc("R11");
    end

    // R12: both directions enabled and moving at once, random traffic
    for (int i = 0; i < 400; i++) begin
      {g0_a_in, g0_b_in} = 16'($urandom);
      {g1_a_in, g1_b_in} = 18'($urandom);
      {g0_le_ab, g0_stb_ab, g0_le_ba, g0_stb_ba} = 4'($urandom);
      {g1_le_ab, g1_stb_ab, g1_le_ba, g1_stb_ba} = 4'($urandom);
      g0_oea = ($urandom % 4) != 0; g0_oea_n = ($urandom % 4) == 0;
      g0_oeb = ($urandom % 4) != 0; g0_oeb_n = ($urandom % 4) == 0;
      g1_oea = ($urandom % 4) != 0; g1_oea_n = ($urandom % 4) == 0;
      g1_oeb = ($urandom % 4) != 0; g1_oeb_n = ($urandom % 4) == 0;
      pwr_ok = ($urandom % 8) != 0;
      cyc("R12");
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule